// File: doc/BRIEF.md
# Accumulating Six-Bit Calculator Datapath

This block executes one arithmetic or logic operation per instruction word. A 16-bit instruction carries an opcode and two 6-bit operand fields. A small decoder turns the opcode into an ALU operation, an operand-source select and a write enable for the result register. A multiplexer picks the ALU inputs, and the ALU produces a 6-bit value together with a carry flag and a borrow/sign flag. The value and both flags are captured in registers.

The top bit of the opcode selects the operand source. When it is clear, the operation works on the two instruction fields. When it is set, the stored previous result becomes the first operand and the instruction's first field becomes the second. This lets a sequence of instructions accumulate into one running value.

An instruction takes effect only when a single-cycle `go` strobe accompanies it. Otherwise the stored result and flags keep their values.

Top module: `acc_calc`

## Requirements
- R1: While `rst` is high at a clock edge, the result and both flags become 0 after that edge.
- R2: The opcode sits in instruction bits [15:12], field A in [11:6] and field B in [5:0]. Opcode 0000 (add) stores (A+B) mod 64, sets carry to bit 6 of the sum and clears borrow.
- R3: Opcode 0001 (subtract) stores (A-B) mod 64, sets borrow when A<B and clears carry. Carry and borrow are never both set.
- R4: Opcode 0010 (increment) stores A+1 mod 64, with carry set only when A=63. Opcode 0011 (decrement) stores A-1 mod 64, with borrow set only when A=0.
- R5: Opcodes 0100 (NOT A), 0101 (A AND B) and 0110 (A OR B) store the bitwise result and clear both flags.
- R6: Opcodes 1000 to 1110 perform the same seven operations with the stored result as first operand and field A as second operand. Field B has no effect.
- R7: Opcodes 0111 and 1111 leave the result and both flags unchanged even with `go` high.
- R8: A clock edge with `go` low leaves the result and both flags unchanged, whatever the instruction.
- R9: An instruction presented with `go` high is visible on the outputs after the next rising edge and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 16 | Instruction word: opcode, field A, field B |
| go | input | 1 | One-cycle execute strobe |
| result | output | 6 | Registered operation result |
| carry | output | 1 | Registered carry out of the 6-bit addition |
| borrow | output | 1 | Registered borrow/sign flag of subtraction |

## Verification
The assertions check the following on every cycle:
- the reset clearing;
- the holding of state without `go` or on a no-op;
- the flag clearing on logic operations;
- the mutual exclusion of carry and borrow;
- the direct-operand and accumulated add results.

Only the bench scenarios show three other behaviours. These are the exact wrap values at 0 and 63, that field B is ignored in accumulate mode, and that a result appears no earlier than the edge after the strobe. The bench checks them with long random chains against its own model and with directed corner cases.

// File: rtl/acc_calc_pkg.sv
package acc_calc_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_INC = 3'd2,
        ALU_DEC = 3'd3,
        ALU_NOT = 3'd4,
        ALU_AND = 3'd5,
        ALU_OR  = 3'd6,
        ALU_NOP = 3'd7
    } alu_op_e;

    typedef struct packed {
        alu_op_e op;
        logic    use_acc;
        logic    wr_en;
    } ctrl_t;

    typedef struct packed {
        logic carry;
        logic borrow;
    } flags_t;

    function automatic logic op_is_logic(alu_op_e op);
        return (op == ALU_NOT) || (op == ALU_AND) || (op == ALU_OR);
    endfunction

    function automatic logic op_is_sub(alu_op_e op);
        return (op == ALU_SUB) || (op == ALU_DEC);
    endfunction

endpackage

// File: rtl/acc_calc_decode.sv
module acc_calc_decode
    import acc_calc_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic             go,
    output ctrl_t            ctrl
);
    always_comb begin
        ctrl.op      = alu_op_e'(opcode[OPC_W-2:0]);
        ctrl.use_acc = opcode[OPC_W-1];
        ctrl.wr_en   = go && (alu_op_e'(opcode[OPC_W-2:0]) != ALU_NOP);
    end
endmodule

// File: rtl/acc_calc_opmux.sv
module acc_calc_opmux #(
    parameter int DATA_W = 6
) (
    input  logic              use_acc,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] fld_a,
    input  logic [DATA_W-1:0] fld_b,
    output logic [DATA_W-1:0] opa,
    output logic [DATA_W-1:0] opb
);
    always_comb begin
        opa = use_acc ? acc   : fld_a;
        opb = use_acc ? fld_a : fld_b;
    end
endmodule

// File: rtl/acc_calc_alu.sv
module acc_calc_alu
    import acc_calc_pkg::*;
#(
    parameter int DATA_W = 6
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] res,
    output flags_t            flags
);
    localparam int EXT_W = DATA_W + 1;

    logic [DATA_W-1:0] rhs;
    logic [EXT_W-1:0]  sum_ext;
    logic [EXT_W-1:0]  diff_ext;

    // increment and decrement reuse the adder with a constant one
    always_comb begin
        rhs      = ((op == ALU_INC) || (op == ALU_DEC)) ? DATA_W'(1) : opb;
        sum_ext  = {1'b0, opa} + {1'b0, rhs};
        diff_ext = {1'b0, opa} - {1'b0, rhs};
    end

    always_comb begin
        res          = '0;
        flags.carry  = 1'b0;
        flags.borrow = 1'b0;
        unique case (op)
            ALU_ADD, ALU_INC: begin
                res         = sum_ext[DATA_W-1:0];
                flags.carry = sum_ext[DATA_W];
            end
            ALU_SUB, ALU_DEC: begin
                res          = diff_ext[DATA_W-1:0];
                flags.borrow = diff_ext[DATA_W];
            end
            ALU_NOT: res = ~opa;
            ALU_AND: res = opa & opb;
            ALU_OR:  res = opa | opb;
            ALU_NOP: res = '0;
        endcase
    end
endmodule

// File: rtl/acc_calc.sv
module acc_calc
    import acc_calc_pkg::*;
#(
    parameter int DATA_W = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [OPC_W+2*DATA_W-1:0]     instr,
    input  logic                          go,
    output logic [DATA_W-1:0]             result,
    output logic                          carry,
    output logic                          borrow
);
    localparam int INSTR_W = OPC_W + 2 * DATA_W;
    localparam int A_LSB   = DATA_W;

    logic [OPC_W-1:0]  opcode;
    logic [DATA_W-1:0] fld_a;
    logic [DATA_W-1:0] fld_b;
    ctrl_t             ctrl;
    logic [DATA_W-1:0] opa;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] alu_res;
    flags_t            alu_flags;
    flags_t            flags_q;

    always_comb begin
        opcode = instr[INSTR_W-1 -: OPC_W];
        fld_a  = instr[A_LSB +: DATA_W];
        fld_b  = instr[DATA_W-1:0];
    end

    acc_calc_decode u_decode (
        .opcode (opcode),
        .go     (go),
        .ctrl   (ctrl)
    );

    acc_calc_opmux #(.DATA_W(DATA_W)) u_opmux (
        .use_acc (ctrl.use_acc),
        .acc     (result),
        .fld_a   (fld_a),
        .fld_b   (fld_b),
        .opa     (opa),
        .opb     (opb)
    );

    acc_calc_alu #(.DATA_W(DATA_W)) u_alu (
        .op    (ctrl.op),
        .opa   (opa),
        .opb   (opb),
        .res   (alu_res),
        .flags (alu_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result  <= '0;
            flags_q <= '0;
        end else if (ctrl.wr_en) begin
            result  <= alu_res;
            flags_q <= alu_flags;
        end
    end

    assign carry  = flags_q.carry;
    assign borrow = flags_q.borrow;
endmodule

// File: rtl/acc_calc_checker.sv
module acc_calc_checker
    import acc_calc_pkg::*;
#(
    parameter int DATA_W = 6
) (
    input logic                      clk,
    input logic                      rst,
    input logic [OPC_W+2*DATA_W-1:0] instr,
    input logic                      go,
    input logic [DATA_W-1:0]         result,
    input logic                      carry,
    input logic                      borrow
);
    localparam int INSTR_W = OPC_W + 2 * DATA_W;

    logic [OPC_W-1:0]  opc;
    logic [DATA_W-1:0] fa;
    logic [DATA_W-1:0] fb;
    assign opc = instr[INSTR_W-1 -: OPC_W];
    assign fa  = instr[DATA_W +: DATA_W];
    assign fb  = instr[DATA_W-1:0];

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (result == '0) && !carry && !borrow);

    a_r2_direct_add: assert property (@(posedge clk) disable iff (rst)
        (go && opc == 4'b0000) |=> result == DATA_W'($past(fa) + $past(fb)));

    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(carry && borrow));

    a_r5_logic_clears_flags: assert property (@(posedge clk) disable iff (rst)
        (go && op_is_logic(alu_op_e'(opc[2:0]))) |=> !carry && !borrow);

    a_r6_acc_add: assert property (@(posedge clk) disable iff (rst)
        (go && opc == 4'b1000) |=> result == DATA_W'($past(result) + $past(fa)));

    a_r7_nop_holds: assert property (@(posedge clk) disable iff (rst)
        (go && opc[2:0] == 3'b111) |=> $stable(result) && $stable(carry) && $stable(borrow));

    a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !go |=> $stable(result) && $stable(carry) && $stable(borrow));
endmodule

bind acc_calc acc_calc_checker #(.DATA_W(DATA_W)) u_checker (
    .clk    (clk),
    .rst    (rst),
    .instr  (instr),
    .go     (go),
    .result (result),
    .carry  (carry),
    .borrow (borrow)
);

// File: tb/acc_calc_bench.sv
module acc_calc_bench;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr = '0;
    logic        go = 1'b0;
    logic [5:0]  result;
    logic        carry;
    logic        borrow;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    logic [5:0] m_res = '0;
    logic       m_c   = 1'b0;
    logic       m_b   = 1'b0;

    acc_calc u_acc_calc (
        .clk(clk), .rst(rst), .instr(instr), .go(go),
        .result(result), .carry(carry), .borrow(borrow)
    );

    always #(PERIOD/2) clk = ~clk;

    // reference: returns {carry, borrow, value}
    function automatic logic [7:0] ref_op(input logic [15:0] ins, input logic [5:0] acc);
        int a, b, r;
        logic c, br;
        a = ins[15] ? acc : ins[11:6];
        b = ins[15] ? ins[11:6] : ins[5:0];
        c = 0; br = 0; r = 0;
        case (ins[14:12])
            3'd0: begin r = a + b; c = (r > 63); end
            3'd1: begin r = a - b; br = (a < b); end
            3'd2: begin r = a + 1; c = (a == 63); end
            3'd3: begin r = a - 1; br = (a == 0); end
            3'd4: r = 63 - a;
            3'd5: r = a & b;
            default: r = a | b;
        endcase
        return {c, br, r[5:0]};
    endfunction

    function automatic string tag_of(input logic [15:0] ins, input logic g);
        if (!g) return "R8";
        if (ins[14:12] == 3'd7) return "R7";
        if (ins[15]) return "R6";
        case (ins[14:12])
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2, 3'd3: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input string tag);
        checks++;
        if (result !== m_res || carry !== m_c || borrow !== m_b) begin
            errors++;
            $display("FAIL %s: got res=%0d c=%0b b=%0b expected res=%0d c=%0b b=%0b",
                     tag, result, carry, borrow, m_res, m_c, m_b);
        end
    endtask

    task automatic apply_model(input logic [15:0] ins);
        logic [7:0] r;
        if (ins[14:12] != 3'd7) begin
            r = ref_op(ins, m_res);
            {m_c, m_b, m_res} = r;
        end
    endtask

    task automatic step(input logic [15:0] ins, input logic g);
        @(negedge clk);
        instr = ins;
        go    = g;
        @(negedge clk);
        go = 1'b0;
        if (g) apply_model(ins);
        chk(tag_of(ins, g));
    endtask

    function automatic logic [15:0] mk(input logic [3:0] op, input logic [5:0] a, input logic [5:0] b);
        return {op, a, b};
    endfunction

    initial begin
        #(PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1");

        step(mk(4'b0000, 6'd63, 6'd1), 1'b1);   // R2 carry wrap
        step(mk(4'b0000, 6'd20, 6'd22), 1'b1);  // R2 no carry
        step(mk(4'b0001, 6'd5, 6'd9), 1'b1);    // R3 borrow
        step(mk(4'b0001, 6'd9, 6'd9), 1'b1);    // R3 zero
        step(mk(4'b0010, 6'd63, 6'd0), 1'b1);   // R4 inc wrap
        step(mk(4'b0011, 6'd0, 6'd0), 1'b1);    // R4 dec below zero
        step(mk(4'b0100, 6'd21, 6'd0), 1'b1);   // R5 NOT
        step(mk(4'b0101, 6'd60, 6'd15), 1'b1);  // R5 AND
        step(mk(4'b0110, 6'd48, 6'd3), 1'b1);   // R5 OR
        step(mk(4'b0000, 6'd10, 6'd0), 1'b1);   // seed accumulator
        step(mk(4'b1000, 6'd7, 6'd63), 1'b1);   // R6 acc add, field B ignored
        step(mk(4'b1000, 6'd7, 6'd0), 1'b1);    // R6 same with other B
        step(mk(4'b1001, 6'd30, 6'd1), 1'b1);   // R6 acc sub borrow
        step(mk(4'b1010, 6'd0, 6'd5), 1'b1);    // R6 acc inc
        step(mk(4'b0111, 6'd1, 6'd2), 1'b1);    // R7
        step(mk(4'b1111, 6'd3, 6'd4), 1'b1);    // R7
        step(mk(4'b0000, 6'd33, 6'd33), 1'b0);  // R8

        // R9: no change before the edge, change after it
        @(negedge clk);
        instr = mk(4'b0000, 6'd1, 6'd2);
        go    = 1'b1;
        #(PERIOD/4);
        chk("R9");
        @(negedge clk);
        go = 1'b0;
        apply_model(instr);
        chk("R9");

        for (int i = 0; i < 400; i++) begin
            logic [15:0] ins;
            ins = 16'($urandom);
            step(ins, ($urandom % 4) != 0);
        end

        // R1 mid-run reset
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_res = '0; m_c = 0; m_b = 0;
        chk("R1");

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
        $finish;
    end
endmodule